// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder

This block sits between an 8-bit processor bus and the devices mapped into the processor's address space. On that bus the low address byte and the data share the same wires. When the address strobe is high, the block captures the shared byte into a register. It then joins that byte with the upper address bits, which the processor drives directly, to form the full address.

The upper address bits pick a region of the memory map. The block turns that region into active-low device selects, each qualified by the E clock and, where it matters, by the direction of the access. The selects cover:

- the upper-half RAM;
- a digital input buffer and a digital output latch, which share one window;
- three motor-control latches.

At most one select is low at any time, so two devices never drive the data lines together. The internal processor memory and register pages get no external select.

Top module: `mbd_top`

## Requirements
- R1: While `rst_n` is low, every select output is high (inactive). The captured low byte is cleared, so `mem_addr[7:0]` reads 0 after reset until a strobe occurs.
- R2: On a rising `clk` edge with `addr_strobe` high, `ad_bus` is captured. Otherwise the captured byte holds. `mem_addr` is {`addr_hi[6:0]`, captured byte}.
- R3: `ram_sel_n` is low exactly when `addr_hi[7]` is 1, `e_clk` is high and reset is released. This maps RAM to 0x8000–0xFFFF.
- R4: `din_sel_n` is low exactly when `addr_hi[7:3]` equals 5'b01111 (window 0x7800–0x7FFF), `rd_wr` is 1 (read) and `e_clk` is high.
- R5: `dout_sel_n` is low exactly when `addr_hi[7:3]` equals 5'b01111, `rd_wr` is 0 (write) and `e_clk` is high.
- R6: Each motor latch select goes low only on a write (`rd_wr` = 0) with `e_clk` high, in its own window:
  - `mot_sel_n[0]` when `addr_hi[7:3]` = 5'b01110 (0x7000);
  - `mot_sel_n[1]` when `addr_hi[7:3]` = 5'b01101 (0x6800);
  - `mot_sel_n[2]` when `addr_hi[7:3]` = 5'b01100 (0x6000).
- R7: At no time is more than one of the six select outputs low.
- R8: Accesses to 0x0000–0x00FF and 0x1000–0x103F drive no select low. No other address below 0x6000 does either.
- R9: While `e_clk` is low, all selects are high whatever the address and direction.
- R10: Inside each input/output or motor window, address bits A10..A0 do not affect which select is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capturing the low address byte |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi | input | 8 | Upper address bits A15..A8 from the processor |
| ad_bus | input | 8 | Shared low-address / data byte |
| addr_strobe | input | 1 | High while `ad_bus` carries the low address byte |
| e_clk | input | 1 | Bus enable clock; selects only act while it is high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| mem_addr | output | 15 | In-RAM address A14..A0 |
| ram_sel_n | output | 1 | RAM select, active low |
| din_sel_n | output | 1 | Digital input buffer enable, active low |
| dout_sel_n | output | 1 | Digital output latch clock, active low |
| mot_sel_n | output | 3 | Motor latch clocks, active low |

## Verification
The hardest situation to reach is a low byte that belongs to a different access from the current upper bits. Stale captured data must never leak into the selects or into the in-RAM address. To reach it, each vector strobes one low byte and then removes the strobe. The bench then drives an unrelated value on `ad_bus`, changes direction and E-clock, and only after that compares the outputs. A sweep covers every upper byte, both directions and both E-clock levels. A mid-run reset, applied while a RAM access is in progress, shows that the selects are forced off and the captured byte is cleared.

// File: rtl/mbd_pkg.sv
`timescale 1ns/1ps
package mbd_pkg;
   localparam int unsigned BUS_ADDR_W = 16;
   localparam int unsigned BUS_LO_W   = 8;

   typedef struct packed {
      logic ram;
      logic dio;
   } mbd_hit_t;

   // Region tag: the top tag_w bits of a base address
   function automatic logic [BUS_ADDR_W-1:0] mbd_tag_of(
      input logic [BUS_ADDR_W-1:0] base, input int unsigned tag_w);
      return base >> (BUS_ADDR_W - tag_w);
   endfunction
endpackage

// File: rtl/mbd_lo_latch.sv
`timescale 1ns/1ps
module mbd_lo_latch #(
   parameter int unsigned LO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strobe,
   input  logic [LO_W-1:0] shared_in,
   output logic [LO_W-1:0] lo_q
);
   generate
      if (LO_W < 1) begin : g_bad_w
         $error("mbd_lo_latch: LO_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lo_q <= '0;
      else if (strobe) lo_q <= shared_in;
   end
endmodule

// File: rtl/mbd_region_dec.sv
`timescale 1ns/1ps
module mbd_region_dec
   import mbd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned HI_W        = 8,
   parameter int unsigned TAG_W       = 5,
   parameter int unsigned NUM_MOT     = 3,
   parameter logic [15:0] DIO_BASE    = 16'h7800,
   parameter logic [15:0] MOT_TOP     = 16'h7000,
   parameter logic [15:0] MOT_STRIDE  = 16'h0800
) (
   input  logic [HI_W-1:0]    addr_hi,
   output mbd_hit_t           hit,
   output logic [NUM_MOT-1:0] mot_hit
);
   localparam int unsigned TAG_SHIFT = ADDR_W - TAG_W;
   localparam logic [TAG_W-1:0] DIO_TAG = TAG_W'(DIO_BASE >> TAG_SHIFT);

   generate
      if (TAG_W > HI_W || TAG_W < 1) begin : g_bad_tag
         $error("mbd_region_dec: TAG_W must be within 1..HI_W");
      end
      if (ADDR_W != BUS_ADDR_W) begin : g_bad_aw
         $error("mbd_region_dec: ADDR_W must match the package bus width");
      end
   endgenerate

   logic [TAG_W-1:0] tag;
   assign tag = addr_hi[HI_W-1 -: TAG_W];

   // RAM occupies the half where the top address bit is set
   assign hit.ram = addr_hi[HI_W-1];
   assign hit.dio = (tag == DIO_TAG);

   for (genvar i = 0; i < NUM_MOT; i++) begin : g_mot
      localparam logic [15:0] M_BASE = MOT_TOP - (16'(i) * MOT_STRIDE);
      localparam logic [TAG_W-1:0] M_TAG = TAG_W'(M_BASE >> TAG_SHIFT);
      if (M_TAG == DIO_TAG || M_BASE[15]) begin : g_overlap
         $error("mbd_region_dec: motor window overlaps another region");
      end
      assign mot_hit[i] = (tag == M_TAG);
   end
endmodule

// File: rtl/mbd_sel_drv.sv
`timescale 1ns/1ps
module mbd_sel_drv
   import mbd_pkg::*;
#(
   parameter int unsigned NUM_MOT = 3
) (
   input  logic               rst_n,
   input  logic               e_clk,
   input  logic               rd_wr,
   input  mbd_hit_t           hit,
   input  logic [NUM_MOT-1:0] mot_hit,
   output logic               ram_sel_n,
   output logic               din_sel_n,
   output logic               dout_sel_n,
   output logic [NUM_MOT-1:0] mot_sel_n
);
   logic live;
   assign live = rst_n & e_clk;

   assign ram_sel_n  = ~(live & hit.ram);
   assign din_sel_n  = ~(live & hit.dio &  rd_wr);
   assign dout_sel_n = ~(live & hit.dio & ~rd_wr);

   for (genvar i = 0; i < NUM_MOT; i++) begin : g_mot
      assign mot_sel_n[i] = ~(live & mot_hit[i] & ~rd_wr);
   end
endmodule

// File: rtl/mbd_top.sv
`timescale 1ns/1ps
module mbd_top
   import mbd_pkg::*;
#(
   parameter int unsigned ADDR_W     = BUS_ADDR_W,
   parameter int unsigned LO_W       = BUS_LO_W,
   parameter int unsigned TAG_W      = 5,
   parameter int unsigned NUM_MOT    = 3,
   parameter logic [15:0] DIO_BASE   = 16'h7800,
   parameter logic [15:0] MOT_TOP    = 16'h7000,
   parameter logic [15:0] MOT_STRIDE = 16'h0800,
   localparam int unsigned HI_W      = ADDR_W - LO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HI_W-1:0]    addr_hi,
   input  logic [LO_W-1:0]    ad_bus,
   input  logic               addr_strobe,
   input  logic               e_clk,
   input  logic               rd_wr,
   output logic [ADDR_W-2:0]  mem_addr,
   output logic               ram_sel_n,
   output logic               din_sel_n,
   output logic               dout_sel_n,
   output logic [NUM_MOT-1:0] mot_sel_n
);
   generate
      if (HI_W < 2) begin : g_bad_split
         $error("mbd_top: too few direct upper address bits");
      end
   endgenerate

   logic [LO_W-1:0]    lo_q;
   mbd_hit_t           hit;
   logic [NUM_MOT-1:0] mot_hit;

   mbd_lo_latch #(.LO_W(LO_W)) lo_latch_i (
      .clk(clk), .rst_n(rst_n), .strobe(addr_strobe),
      .shared_in(ad_bus), .lo_q(lo_q));

   mbd_region_dec #(
      .ADDR_W(ADDR_W), .HI_W(HI_W), .TAG_W(TAG_W), .NUM_MOT(NUM_MOT),
      .DIO_BASE(DIO_BASE), .MOT_TOP(MOT_TOP), .MOT_STRIDE(MOT_STRIDE)
   ) region_i (
      .addr_hi(addr_hi), .hit(hit), .mot_hit(mot_hit));

   mbd_sel_drv #(.NUM_MOT(NUM_MOT)) drv_i (
      .rst_n(rst_n), .e_clk(e_clk), .rd_wr(rd_wr), .hit(hit),
      .mot_hit(mot_hit), .ram_sel_n(ram_sel_n), .din_sel_n(din_sel_n),
      .dout_sel_n(dout_sel_n), .mot_sel_n(mot_sel_n));

   assign mem_addr = {addr_hi[HI_W-2:0], lo_q};
endmodule

// File: rtl/mbd_checker.sv
`timescale 1ns/1ps
module mbd_checker #(
   parameter int unsigned HI_W    = 8,
   parameter int unsigned LO_W    = 8,
   parameter int unsigned NUM_MOT = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [HI_W-1:0]    addr_hi,
   input logic [LO_W-1:0]    ad_bus,
   input logic               addr_strobe,
   input logic               e_clk,
   input logic               rd_wr,
   input logic [HI_W+LO_W-2:0] mem_addr,
   input logic               ram_sel_n,
   input logic               din_sel_n,
   input logic               dout_sel_n,
   input logic [NUM_MOT-1:0] mot_sel_n
);
   logic [NUM_MOT+2:0] all_n;
   assign all_n = {mot_sel_n, dout_sel_n, din_sel_n, ram_sel_n};

   AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(addr_strobe) |-> mem_addr[LO_W-1:0] == $past(ad_bus)); // R2
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(addr_strobe) |-> $stable(mem_addr[LO_W-1:0])); // R2
   AST_RAM_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_sel_n |-> (addr_hi[HI_W-1] && e_clk)); // R3
   AST_DIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !din_sel_n |-> rd_wr); // R4
   AST_DOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_sel_n |-> !rd_wr); // R5
   AST_MOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(&mot_sel_n) |-> !rd_wr); // R6
   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~all_n) <= 1); // R7
   AST_INTERNAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_hi == '0 || addr_hi == HI_W'(8'h10)) |-> &all_n); // R8
   AST_E_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !e_clk |-> &all_n); // R9
endmodule

bind mbd_top mbd_checker #(.HI_W(HI_W), .LO_W(LO_W), .NUM_MOT(NUM_MOT)) chk_i (
   .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .ad_bus(ad_bus),
   .addr_strobe(addr_strobe), .e_clk(e_clk), .rd_wr(rd_wr),
   .mem_addr(mem_addr), .ram_sel_n(ram_sel_n), .din_sel_n(din_sel_n),
   .dout_sel_n(dout_sel_n), .mot_sel_n(mot_sel_n));

// File: tb/mbd_top_tb_top.sv
`timescale 1ns/1ps
module mbd_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr_hi = '0;
   logic [7:0] ad_bus = '0;
   logic       addr_strobe = 1'b0;
   logic       e_clk = 1'b0;
   logic       rd_wr = 1'b1;
   logic [14:0] mem_addr;
   logic       ram_sel_n, din_sel_n, dout_sel_n;
   logic [2:0] mot_sel_n;

   int vectors = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mbd_top dut_i (
      .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .ad_bus(ad_bus),
      .addr_strobe(addr_strobe), .e_clk(e_clk), .rd_wr(rd_wr),
      .mem_addr(mem_addr), .ram_sel_n(ram_sel_n), .din_sel_n(din_sel_n),
      .dout_sel_n(dout_sel_n), .mot_sel_n(mot_sel_n));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s addr_hi=%02h rw=%0b e=%0b actual=%0h expected=%0h",
                  req, addr_hi, rd_wr, e_clk, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   // Strobe lo on one cycle, then present a stale byte and the access controls
   task automatic apply(input logic [7:0] hi, input logic [7:0] lo,
                        input logic rw, input logic e);
      @(negedge clk);
      addr_hi = hi; ad_bus = lo; addr_strobe = 1'b1; e_clk = 1'b0;
      @(negedge clk);
      addr_strobe = 1'b0; ad_bus = ~lo ^ 8'h5a; rd_wr = rw; e_clk = e;
      #1;
   endtask

   task automatic check_outputs(input logic [7:0] hi, input logic [7:0] lo,
                                input logic rw, input logic e);
      logic [4:0] tag;
      logic [2:0] exp_mot;
      string rq;
      tag = hi[7:3];
      for (int i = 0; i < 3; i++)
         exp_mot[i] = !(e && !rw && tag == 5'(5'b01110 - i));
      check("R2 mem_addr", 32'(mem_addr), 32'({hi[6:0], lo}));
      rq = !e ? "R9" : (hi == 8'h00 || hi == 8'h10) ? "R8" : "R3";
      check({rq, " ram_sel_n"}, 32'(ram_sel_n), 32'(!(e && hi[7])));
      rq = !e ? "R9" : (hi < 8'h60) ? "R8" : (tag == 5'b01111) ? "R4 R10" : "R4";
      check({rq, " din_sel_n"}, 32'(din_sel_n), 32'(!(e && rw && tag == 5'b01111)));
      rq = !e ? "R9" : (hi < 8'h60) ? "R8" : (tag == 5'b01111) ? "R5 R10" : "R5";
      check({rq, " dout_sel_n"}, 32'(dout_sel_n), 32'(!(e && !rw && tag == 5'b01111)));
      rq = !e ? "R9" : (hi < 8'h60) ? "R8" : "R6 R10";
      check({rq, " mot_sel_n"}, 32'(mot_sel_n), 32'(exp_mot));
      check("R7 one select", 32'($countones(~{mot_sel_n, dout_sel_n, din_sel_n, ram_sel_n}) <= 1), 32'd1);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset state with an active-looking RAM access
      addr_hi = 8'hC3; e_clk = 1'b1; rd_wr = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 selects in reset", 32'({mot_sel_n, dout_sel_n, din_sel_n, ram_sel_n}), 32'h3f);
      check("R1 low byte cleared", 32'(mem_addr[7:0]), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 low byte after release", 32'(mem_addr[7:0]), 32'h0);

      // Sweep every upper byte, direction and E level
      for (int h = 0; h < 256; h++)
         for (int rw = 0; rw < 2; rw++)
            for (int e = 0; e < 2; e++) begin
               logic [7:0] lo;
               lo = 8'((h * 37) + (rw * 91) + (e * 13));
               apply(8'(h), lo, rw[0], e[0]);
               check_outputs(8'(h), lo, rw[0], e[0]);
            end

      // R8: internal register page with low bytes at both ends
      apply(8'h10, 8'h00, 1'b1, 1'b1); check_outputs(8'h10, 8'h00, 1'b1, 1'b1);
      apply(8'h10, 8'h3f, 1'b0, 1'b1); check_outputs(8'h10, 8'h3f, 1'b0, 1'b1);
      apply(8'h00, 8'hff, 1'b0, 1'b1); check_outputs(8'h00, 8'hff, 1'b0, 1'b1);

      // R2: byte holds over several idle cycles with changing ad_bus
      apply(8'h9a, 8'hb6, 1'b1, 1'b1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); ad_bus = 8'(k * 77 + 1);
         #1 check("R2 hold", 32'(mem_addr), 32'({7'h1a, 8'hb6}));
      end

      // R1: reset mid-access forces selects off and clears the byte
      @(negedge clk); rst_n = 1'b0; #1;
      check("R1 mid-run reset selects", 32'({mot_sel_n, dout_sel_n, din_sel_n, ram_sel_n}), 32'h3f);
      check("R1 mid-run reset byte", 32'(mem_addr[7:0]), 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule